// File: doc/BRIEF.md
# Second-Level Coherence Snoop Filter

This block is the coherence engine on the bus side of a second-level cache that sits behind a small first-level cache. It keeps a per-line directory with a valid bit, tag, sharing state, inclusion bit, write-buffer bit, first-level-dirty bit, second-level-dirty bit and a pointer to the line's slot in the first level. Snooped bus requests are resolved against this directory. The first level is only involved when the directory shows that it holds the line or holds newer data for it. Otherwise the snoop is absorbed at the second level.

The processor side sends fills after misses in both levels, write-permission requests for clean first-level lines, and bookkeeping notices: clean eviction, move of a dirty line into the write buffer, and drain of that buffer. The engine runs an invalidation protocol with shared and private states.

It handles one request at a time. While `busy` is high, new requests are ignored, and the requester has to present them again later.

The FSM states are:

| State | Role |
|---|---|
| `ST_IDLE` | Waits for a request. |
| `ST_SNP_EVAL` | Classifies a snoop. |
| `ST_FLUSH_WAIT` | Holds a first-level flush until it is acknowledged. |
| `ST_SNP_SUPPLY` | Drives the data and memory-update strobes. |
| `ST_SNP_INV` | Drops the line and, if the line is included, invalidates the first-level copy. |
| `ST_CPU_EVAL` | Classifies a processor request and applies bookkeeping. |
| `ST_BUS_WAIT` | Holds a bus transaction until it is done. |
| `ST_GRANT` | Pulses the grant to the first level. |

The transitions are:

| From | Condition | To |
|---|---|---|
| `ST_IDLE` | snoop valid | `ST_SNP_EVAL` |
| `ST_IDLE` | processor request valid, no snoop | `ST_CPU_EVAL` |
| `ST_SNP_EVAL` | invalidation | `ST_SNP_INV` |
| `ST_SNP_EVAL` | first-level data or buffered data | `ST_FLUSH_WAIT` |
| `ST_SNP_EVAL` | only the second level dirty | `ST_SNP_SUPPLY` |
| `ST_SNP_EVAL` | otherwise, read-modify-write | `ST_SNP_INV` |
| `ST_SNP_EVAL` | otherwise | `ST_IDLE` |
| `ST_FLUSH_WAIT` | flush acknowledged | `ST_SNP_SUPPLY` |
| `ST_SNP_SUPPLY` | read-modify-write | `ST_SNP_INV` |
| `ST_SNP_SUPPLY` | otherwise | `ST_IDLE` |
| `ST_SNP_INV` | always | `ST_IDLE` |
| `ST_CPU_EVAL` | a bus transaction is needed | `ST_BUS_WAIT` |
| `ST_CPU_EVAL` | permission on a private hit | `ST_GRANT` |
| `ST_CPU_EVAL` | otherwise | `ST_IDLE` |
| `ST_BUS_WAIT` | bus done | `ST_GRANT` |
| `ST_GRANT` | always | `ST_IDLE` |

Top module: `l2sf_engine`

## Requirements
- R1: A snoop read (kind 0) or read-modify-write (kind 2) that hits a line dirty in the first level holds `l1_flush_req` with `l1_flush_buf`=0 and `l1_ptr` equal to the line's first-level pointer until `l1_flush_ack`. The cycle after the acknowledge it pulses `bus_supply` and `mem_update` together. Afterwards the line is shared and clean at both levels, and its inclusion bit is kept.
- R2: A snoop read or read-modify-write that hits a line whose dirty data sits in the write buffer sends the flush with `l1_flush_buf`=1, then supplies and updates memory as in R1. It also clears the inclusion bit and the buffer bit. When both the first-level-dirty bit and the buffer bit are set, R1 takes priority.
- R3: A snoop read or read-modify-write that hits a line dirty only at the second level pulses `bus_supply` and `mem_update` with no first-level message, and leaves the line shared and clean. A miss, or a hit on a clean line, produces no supply strobe, so memory provides the data.
- R4: `snp_shared` pulses for one cycle, the cycle after a snoop is accepted, whenever a snoop read (kind 0, or kind 3 treated as a read) or read-modify-write hits. Hit means the line is valid and its stored tag equals the address bits above the index.
- R5: A snoop invalidation (kind 1) that hits drops the line. It pulses `l1_inv` with `l1_ptr` equal to the first-level pointer only if the inclusion bit was set.
- R6: A snoop read-modify-write performs the R1–R3 and R4 read handling and then the R5 invalidation.
- R7: A write-permission request (`cpu_op` 2) that hits a private line pulses `l1_grant` with no bus activity. On a shared line it first holds `bus_req` with `bus_kind` 1 until `bus_done`, then pulses `l1_grant`. In both cases the line ends private and dirty in the first level. A request that misses has no effect.
- R8: A fill after a read miss (`cpu_op` 0) holds `bus_req` with `bus_kind` 0 until `bus_done`, then pulses `l1_grant`. It installs the line with the request's tag and pointer, clean, with the inclusion bit set. The line is shared if `bus_shared` was high with `bus_done`, and private otherwise.
- R9: A fill after a write miss (`cpu_op` 1) holds `bus_req` with `bus_kind` 2 until `bus_done`, then pulses `l1_grant`. It installs the line private, clean at the second level and dirty in the first level.
- R10: Bookkeeping requests take effect only on a hit and cause no bus or first-level output. Op 3 clears the inclusion bit. Op 4 sets the buffer bit and clears the first-level-dirty bit. Op 5 clears the buffer bit and sets the second-level-dirty bit. Ops 6 and 7 do nothing.
- R11: `busy` is low only in idle, and requests presented while `busy` is high are ignored. A snoop and a processor request in the same idle cycle accept only the snoop. At most one of `l1_flush_req`, `l1_inv`, `l1_grant` is high at a time.
- R12: After reset every line is invalid and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snooped bus request present |
| snp_kind | input | 2 | 0 read, 1 invalidation, 2 read-modify-write, 3 treated as read |
| snp_addr | input | TAG_W+IDX_W | Snooped line address, index in the low bits |
| cpu_valid | input | 1 | Processor-side request present |
| cpu_op | input | 3 | Processor request code (see R7–R10) |
| cpu_addr | input | TAG_W+IDX_W | Processor request line address |
| cpu_vptr | input | VPTR_W | First-level slot for a fill |
| busy | output | 1 | Engine is working on a request |
| snp_shared | output | 1 | Sharing acknowledge for a snoop |
| l1_flush_req | output | 1 | Flush request to the first level |
| l1_flush_buf | output | 1 | Flush targets the write buffer rather than the slot |
| l1_flush_ack | input | 1 | First level has returned the flushed data |
| l1_inv | output | 1 | Invalidate the first-level slot |
| l1_ptr | output | VPTR_W | Slot pointer for flush or invalidate |
| l1_grant | output | 1 | Write permission or fill complete |
| bus_req | output | 1 | Bus transaction request |
| bus_kind | output | 2 | 0 read, 1 invalidation, 2 read-modify-write |
| bus_done | input | 1 | Bus transaction complete |
| bus_shared | input | 1 | Another cache holds the line (valid with bus_done) |
| bus_supply | output | 1 | This cache drives the line's data |
| mem_update | output | 1 | Memory is written with the supplied data |

## Verification
The directory has no read port, so a corrupted flag only becomes visible the next time a request touches that line. A lost dirty bit shows as a missing flush or supply on the next snoop read. A lost inclusion bit shows as a missing `l1_inv` on a later invalidation. A wrong sharing state shows as an unexpected or missing bus invalidation on the next write-permission request. The sweep therefore follows every state-building sequence and every snoop with a read snoop and an invalidation of the same line. This brings any stale flag out at the ports within a few cycles.

// File: rtl/l2sf_pkg.sv
package l2sf_pkg;

    typedef enum logic [1:0] {
        BK_READ = 2'd0,
        BK_INV  = 2'd1,
        BK_RMW  = 2'd2,
        BK_RSVD = 2'd3
    } bus_kind_e;

    typedef enum logic [2:0] {
        OP_RDMISS = 3'd0,
        OP_WRMISS = 3'd1,
        OP_WRPERM = 3'd2,
        OP_DROP   = 3'd3,
        OP_PUSH   = 3'd4,
        OP_WBACK  = 3'd5,
        OP_NOP6   = 3'd6,
        OP_NOP7   = 3'd7
    } cpu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SNP_EVAL,
        ST_FLUSH_WAIT,
        ST_SNP_SUPPLY,
        ST_SNP_INV,
        ST_CPU_EVAL,
        ST_BUS_WAIT,
        ST_GRANT
    } state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_FLUSH_L1,
        ACT_FLUSH_BUF,
        ACT_SUPPLY_L2
    } snp_act_e;

    typedef struct packed {
        logic valid;
        logic shared;
        logic incl;
        logic wbuf;
        logic l1_dirty;
        logic l2_dirty;
    } line_flags_t;

endpackage

// File: rtl/l2sf_dir.sv
module l2sf_dir
    import l2sf_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 4,
    parameter int VPTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_flags_t       rd_flags,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [VPTR_W-1:0] rd_vptr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_flags_t       wr_flags,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [VPTR_W-1:0] wr_vptr
);
    localparam int LINES = 1 << IDX_W;

    line_flags_t       flags_arr [LINES];
    logic [TAG_W-1:0]  tag_arr   [LINES];
    logic [VPTR_W-1:0] vptr_arr  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_flags_t       f_q;
        logic [TAG_W-1:0]  t_q;
        logic [VPTR_W-1:0] p_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f_q <= '0;
                t_q <= '0;
                p_q <= '0;
            end else if (sel) begin
                f_q <= wr_flags;
                t_q <= wr_tag;
                p_q <= wr_vptr;
            end
        end

        assign flags_arr[g] = f_q;
        assign tag_arr[g]   = t_q;
        assign vptr_arr[g]  = p_q;
    end

    assign rd_flags = flags_arr[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];
    assign rd_vptr  = vptr_arr[rd_idx];

endmodule

// File: rtl/l2sf_classify.sv
module l2sf_classify
    import l2sf_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  line_flags_t      flags,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    input  bus_kind_e        kind,
    output logic             hit,
    output logic             share_ack,
    output snp_act_e         act,
    output logic             inv_l1
);
    logic is_inv;

    assign is_inv    = (kind == BK_INV);
    assign hit       = flags.valid && (line_tag == req_tag);
    assign share_ack = hit && !is_inv;
    assign inv_l1    = hit && flags.incl;

    // Newest copy wins: first-level slot, then write buffer, then second level.
    always_comb begin
        act = ACT_NONE;
        if (!is_inv && hit) begin
            if (flags.l1_dirty)      act = ACT_FLUSH_L1;
            else if (flags.wbuf)     act = ACT_FLUSH_BUF;
            else if (flags.l2_dirty) act = ACT_SUPPLY_L2;
        end
    end

endmodule

// File: rtl/l2sf_engine.sv
module l2sf_engine
    import l2sf_pkg::*;
#(
    parameter  int IDX_W  = 3,
    parameter  int TAG_W  = 4,
    parameter  int VPTR_W = 4,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              cpu_valid,
    input  logic [2:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [VPTR_W-1:0] cpu_vptr,
    output logic              busy,
    output logic              snp_shared,
    output logic              l1_flush_req,
    output logic              l1_flush_buf,
    input  logic              l1_flush_ack,
    output logic              l1_inv,
    output logic [VPTR_W-1:0] l1_ptr,
    output logic              l1_grant,
    output logic              bus_req,
    output logic [1:0]        bus_kind,
    input  logic              bus_done,
    input  logic              bus_shared,
    output logic              bus_supply,
    output logic              mem_update
);
    state_e            state_q, state_d;
    bus_kind_e         req_kind_q;
    cpu_op_e           req_op_q;
    logic [IDX_W-1:0]  req_idx_q;
    logic [TAG_W-1:0]  req_tag_q;
    logic [VPTR_W-1:0] req_vptr_q;

    line_flags_t       cur_flags;
    logic [TAG_W-1:0]  cur_tag;
    logic [VPTR_W-1:0] cur_vptr;

    logic              wr_en;
    line_flags_t       wr_flags;
    logic [TAG_W-1:0]  wr_tag;
    logic [VPTR_W-1:0] wr_vptr;

    logic              hit, share_ack, inv_l1;
    snp_act_e          act;
    bus_kind_e         op_bus_kind;
    logic              is_rmw;

    l2sf_dir #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .VPTR_W(VPTR_W)
    ) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_idx_q),
        .rd_flags(cur_flags),
        .rd_tag  (cur_tag),
        .rd_vptr (cur_vptr),
        .wr_en   (wr_en),
        .wr_idx  (req_idx_q),
        .wr_flags(wr_flags),
        .wr_tag  (wr_tag),
        .wr_vptr (wr_vptr)
    );

    l2sf_classify #(
        .TAG_W(TAG_W)
    ) u_cls (
        .flags    (cur_flags),
        .line_tag (cur_tag),
        .req_tag  (req_tag_q),
        .kind     (req_kind_q),
        .hit      (hit),
        .share_ack(share_ack),
        .act      (act),
        .inv_l1   (inv_l1)
    );

    assign is_rmw = (req_kind_q == BK_RMW);

    always_comb begin
        unique case (req_op_q)
            OP_WRMISS: op_bus_kind = BK_RMW;
            OP_WRPERM: op_bus_kind = BK_INV;
            default:   op_bus_kind = BK_READ;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_kind_q <= BK_READ;
            req_op_q   <= OP_NOP6;
            req_idx_q  <= '0;
            req_tag_q  <= '0;
            req_vptr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                if (snp_valid) begin
                    req_kind_q <= bus_kind_e'(snp_kind);
                    req_idx_q  <= snp_addr[IDX_W-1:0];
                    req_tag_q  <= snp_addr[ADDR_W-1:IDX_W];
                end else if (cpu_valid) begin
                    req_op_q   <= cpu_op_e'(cpu_op);
                    req_idx_q  <= cpu_addr[IDX_W-1:0];
                    req_tag_q  <= cpu_addr[ADDR_W-1:IDX_W];
                    req_vptr_q <= cpu_vptr;
                end
            end
        end
    end

    // Next state and directory update.
    always_comb begin
        state_d  = state_q;
        wr_en    = 1'b0;
        wr_flags = cur_flags;
        wr_tag   = cur_tag;
        wr_vptr  = cur_vptr;

        unique case (state_q)
            ST_IDLE: begin
                if (snp_valid)      state_d = ST_SNP_EVAL;
                else if (cpu_valid) state_d = ST_CPU_EVAL;
            end

            ST_SNP_EVAL: begin
                if (req_kind_q == BK_INV) begin
                    state_d = ST_SNP_INV;
                end else begin
                    unique case (act)
                        ACT_FLUSH_L1,
                        ACT_FLUSH_BUF: state_d = ST_FLUSH_WAIT;
                        ACT_SUPPLY_L2: state_d = ST_SNP_SUPPLY;
                        default:       state_d = is_rmw ? ST_SNP_INV : ST_IDLE;
                    endcase
                end
            end

            ST_FLUSH_WAIT: begin
                if (l1_flush_ack) begin
                    wr_en             = 1'b1;
                    wr_flags.l1_dirty = 1'b0;
                    wr_flags.wbuf     = 1'b0;
                    if (act == ACT_FLUSH_BUF) wr_flags.incl = 1'b0;
                    state_d = ST_SNP_SUPPLY;
                end
            end

            ST_SNP_SUPPLY: begin
                wr_en             = 1'b1;
                wr_flags.shared   = 1'b1;
                wr_flags.l1_dirty = 1'b0;
                wr_flags.l2_dirty = 1'b0;
                wr_flags.wbuf     = 1'b0;
                state_d = is_rmw ? ST_SNP_INV : ST_IDLE;
            end

            ST_SNP_INV: begin
                if (hit) begin
                    wr_en    = 1'b1;
                    wr_flags = '0;
                end
                state_d = ST_IDLE;
            end

            ST_CPU_EVAL: begin
                state_d = ST_IDLE;
                unique case (req_op_q)
                    OP_RDMISS,
                    OP_WRMISS: state_d = ST_BUS_WAIT;
                    OP_WRPERM: begin
                        if (hit && cur_flags.shared) begin
                            state_d = ST_BUS_WAIT;
                        end else if (hit) begin
                            wr_en             = 1'b1;
                            wr_flags.l1_dirty = 1'b1;
                            state_d           = ST_GRANT;
                        end
                    end
                    OP_DROP: begin
                        wr_en         = hit;
                        wr_flags.incl = 1'b0;
                    end
                    OP_PUSH: begin
                        wr_en             = hit;
                        wr_flags.wbuf     = 1'b1;
                        wr_flags.l1_dirty = 1'b0;
                    end
                    OP_WBACK: begin
                        wr_en             = hit;
                        wr_flags.wbuf     = 1'b0;
                        wr_flags.l2_dirty = 1'b1;
                    end
                    default: ;
                endcase
            end

            ST_BUS_WAIT: begin
                if (bus_done) begin
                    wr_en   = 1'b1;
                    state_d = ST_GRANT;
                    unique case (req_op_q)
                        OP_WRPERM: begin
                            wr_flags.shared   = 1'b0;
                            wr_flags.l1_dirty = 1'b1;
                        end
                        OP_WRMISS: begin
                            wr_flags          = '0;
                            wr_flags.valid    = 1'b1;
                            wr_flags.incl     = 1'b1;
                            wr_flags.l1_dirty = 1'b1;
                            wr_tag            = req_tag_q;
                            wr_vptr           = req_vptr_q;
                        end
                        default: begin
                            wr_flags        = '0;
                            wr_flags.valid  = 1'b1;
                            wr_flags.incl   = 1'b1;
                            wr_flags.shared = bus_shared;
                            wr_tag          = req_tag_q;
                            wr_vptr         = req_vptr_q;
                        end
                    endcase
                end
            end

            ST_GRANT: state_d = ST_IDLE;

            default: state_d = ST_IDLE;
        endcase
    end

    // Moore outputs.
    always_comb begin
        busy         = (state_q != ST_IDLE);
        snp_shared   = 1'b0;
        l1_flush_req = 1'b0;
        l1_flush_buf = 1'b0;
        l1_inv       = 1'b0;
        l1_ptr       = '0;
        l1_grant     = 1'b0;
        bus_req      = 1'b0;
        bus_kind     = BK_READ;
        bus_supply   = 1'b0;
        mem_update   = 1'b0;
        unique case (state_q)
            ST_SNP_EVAL: snp_shared = share_ack;
            ST_FLUSH_WAIT: begin
                l1_flush_req = 1'b1;
                l1_flush_buf = (act == ACT_FLUSH_BUF);
                l1_ptr       = cur_vptr;
            end
            ST_SNP_SUPPLY: begin
                bus_supply = 1'b1;
                mem_update = 1'b1;
            end
            ST_SNP_INV: begin
                l1_inv = inv_l1;
                if (inv_l1) l1_ptr = cur_vptr;
            end
            ST_BUS_WAIT: begin
                bus_req  = 1'b1;
                bus_kind = op_bus_kind;
            end
            ST_GRANT: l1_grant = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/l2sf_checker.sv
module l2sf_checker #(
    parameter int VPTR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              snp_shared,
    input logic              l1_flush_req,
    input logic              l1_flush_buf,
    input logic              l1_flush_ack,
    input logic              l1_inv,
    input logic [VPTR_W-1:0] l1_ptr,
    input logic              l1_grant,
    input logic              bus_req,
    input logic [1:0]        bus_kind,
    input logic              bus_done,
    input logic              bus_supply,
    input logic              mem_update
);
    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        l1_flush_req && !l1_flush_ack |=> l1_flush_req && $stable(l1_ptr) && $stable(l1_flush_buf)); // R1

    AST_FLUSH_TO_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        l1_flush_req && l1_flush_ack |=> bus_supply && mem_update); // R2

    AST_SUPPLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_supply |=> !bus_supply); // R3

    AST_SHARED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |=> !snp_shared); // R4

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_kind)); // R7

    AST_BUS_TO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_done |=> l1_grant); // R8

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(l1_flush_req || l1_inv || l1_grant || bus_req || bus_supply || snp_shared)); // R11

    AST_ONE_L1_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({l1_flush_req, l1_inv, l1_grant})); // R11

endmodule

bind l2sf_engine l2sf_checker #(.VPTR_W(VPTR_W)) u_chk (.*);

// File: tb/tb_l2sf_engine.sv
module tb_l2sf_engine;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 3;
    localparam int TAG_W  = 4;
    localparam int VPTR_W = 4;
    localparam int LINES  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snp_valid = 1'b0;
    logic [1:0] snp_kind = '0;
    logic [6:0] snp_addr = '0;
    logic cpu_valid = 1'b0;
    logic [2:0] cpu_op = '0;
    logic [6:0] cpu_addr = '0;
    logic [3:0] cpu_vptr = '0;
    logic busy, snp_shared, l1_flush_req, l1_flush_buf, l1_inv, l1_grant;
    logic bus_req, bus_supply, mem_update;
    logic [1:0] bus_kind;
    logic [3:0] l1_ptr;
    logic l1_flush_ack = 1'b0;
    logic bus_done = 1'b0;
    logic bus_shared = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference directory
    bit       mv[LINES], msh[LINES], mincl[LINES], mbuf[LINES], mvd[LINES], mrd[LINES];
    bit [3:0] mtag[LINES], mvp[LINES];

    always #(CLK_PERIOD/2) clk = ~clk;

    l2sf_engine #(.IDX_W(IDX_W), .TAG_W(TAG_W), .VPTR_W(VPTR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_vptr(cpu_vptr),
        .busy(busy), .snp_shared(snp_shared),
        .l1_flush_req(l1_flush_req), .l1_flush_buf(l1_flush_buf), .l1_flush_ack(l1_flush_ack),
        .l1_inv(l1_inv), .l1_ptr(l1_ptr), .l1_grant(l1_grant),
        .bus_req(bus_req), .bus_kind(bus_kind), .bus_done(bus_done), .bus_shared(bus_shared),
        .bus_supply(bus_supply), .mem_update(mem_update)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    task automatic compare(input string tag, input logic [17:0] got, input logic [17:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Event vector: {shared, flush, fbuf, supply, mem, inv, grant, busreq, bkind[1:0], fptr[3:0], iptr[3:0]}
    task automatic run_txn(input bit do_snp, input logic [1:0] skind, input bit do_cpu,
                           input logic [2:0] op, input logic [6:0] addr, input logic [3:0] vptr,
                           input bit bsh, input int dly, input bit inject);
        int i = int'(addr[2:0]);
        logic [3:0] tg = addr[6:3];
        bit hit = mv[i] && (mtag[i] == tg);
        bit e_sh = 0, e_fl = 0, e_fb = 0, e_sup = 0, e_inv = 0, e_gr = 0, e_br = 0;
        logic [1:0] e_bk = 2'd0;
        logic [3:0] e_fp = 4'd0, e_ip = 4'd0;
        bit o_sh = 0, o_fl = 0, o_fb = 0, o_sup = 0, o_mem = 0, o_inv = 0, o_gr = 0, o_br = 0;
        logic [1:0] o_bk = 2'd0;
        logic [3:0] o_fp = 4'd0, o_ip = 4'd0;
        int fcnt = 0, bcnt = 0;
        bit done = 0;
        string tag;

        // expected behaviour and model update
        if (do_snp) begin
            tag = (skind == 2'd1) ? "R5" : (skind == 2'd2) ? "R6" : "R4";
            if (skind != 2'd1) begin
                e_sh = hit;
                if (hit && mvd[i]) begin
                    e_fl = 1; e_fb = 0; e_fp = mvp[i]; e_sup = 1;
                    if (skind != 2'd2) tag = "R1";
                end else if (hit && mbuf[i]) begin
                    e_fl = 1; e_fb = 1; e_fp = mvp[i]; e_sup = 1; mincl[i] = 0;
                    if (skind != 2'd2) tag = "R2";
                end else if (hit && mrd[i]) begin
                    e_sup = 1;
                    if (skind != 2'd2) tag = "R3";
                end
                if (e_sup) begin msh[i] = 1; mrd[i] = 0; mvd[i] = 0; mbuf[i] = 0; end
            end
            if (skind == 2'd1 || skind == 2'd2) begin
                if (hit && mincl[i]) begin e_inv = 1; e_ip = mvp[i]; end
                if (hit) begin
                    mv[i] = 0; msh[i] = 0; mincl[i] = 0; mbuf[i] = 0; mvd[i] = 0; mrd[i] = 0;
                end
            end
            if (do_cpu) tag = "R11";
        end else begin
            case (op)
                3'd0: begin
                    tag = "R8"; e_br = 1; e_bk = 2'd0; e_gr = 1;
                    mv[i] = 1; mtag[i] = tg; mvp[i] = vptr; msh[i] = bsh; mincl[i] = 1;
                    mbuf[i] = 0; mvd[i] = 0; mrd[i] = 0;
                end
                3'd1: begin
                    tag = "R9"; e_br = 1; e_bk = 2'd2; e_gr = 1;
                    mv[i] = 1; mtag[i] = tg; mvp[i] = vptr; msh[i] = 0; mincl[i] = 1;
                    mbuf[i] = 0; mvd[i] = 1; mrd[i] = 0;
                end
                3'd2: begin
                    tag = "R7";
                    if (hit) begin
                        e_gr = 1;
                        if (msh[i]) begin e_br = 1; e_bk = 2'd1; end
                        msh[i] = 0; mvd[i] = 1;
                    end
                end
                3'd3: begin tag = "R10"; if (hit) mincl[i] = 0; end
                3'd4: begin tag = "R10"; if (hit) begin mbuf[i] = 1; mvd[i] = 0; end end
                3'd5: begin tag = "R10"; if (hit) begin mbuf[i] = 0; mrd[i] = 1; end end
                default: tag = "R10";
            endcase
        end
        if (inject) tag = "R11";

        // drive
        for (int w = 0; w < 50 && busy; w++) @(negedge clk);
        snp_valid = do_snp; snp_kind = skind; snp_addr = addr;
        cpu_valid = do_cpu; cpu_op = op; cpu_addr = addr; cpu_vptr = vptr;
        @(negedge clk);
        snp_valid = 0; cpu_valid = 0;
        for (int c = 0; c < 60; c++) begin
            l1_flush_ack = 0; bus_done = 0; bus_shared = 0;
            if (inject && c == 0) begin
                cpu_valid = 1; cpu_op = 3'd3; cpu_addr = addr;
            end else begin
                cpu_valid = 0;
            end
            if (!busy) begin done = 1; break; end
            if (snp_shared) o_sh = 1;
            if (l1_flush_req) begin
                o_fl = 1; o_fb = l1_flush_buf; o_fp = l1_ptr;
                if (fcnt >= dly) l1_flush_ack = 1;
                fcnt++;
            end
            if (l1_inv) begin o_inv = 1; o_ip = l1_ptr; end
            if (bus_supply) o_sup = 1;
            if (mem_update) o_mem = 1;
            if (l1_grant) o_gr = 1;
            if (bus_req) begin
                o_br = 1; o_bk = bus_kind;
                if (bcnt >= dly) begin bus_done = 1; bus_shared = bsh; end
                bcnt++;
            end
            @(negedge clk);
        end
        cpu_valid = 0;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL R11 handshake timeout: got busy=1 expected busy=0");
        end
        compare(tag, {o_sh, o_fl, o_fb, o_sup, o_mem, o_inv, o_gr, o_br, o_bk, o_fp, o_ip},
                     {e_sh, e_fl, e_fb, e_sup, e_sup, e_inv, e_gr, e_br, e_bk, e_fp, e_ip});
    endtask

    task automatic snoop(input logic [1:0] k, input logic [6:0] a, input int dly);
        run_txn(1, k, 0, 3'd0, a, 4'd0, 0, dly, 0);
    endtask

    task automatic cpu(input logic [2:0] op, input logic [6:0] a, input logic [3:0] p, input bit bsh, input int dly);
        run_txn(0, 2'd0, 1, op, a, p, bsh, dly, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R11 watchdog: got running expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            mv[i] = 0; msh[i] = 0; mincl[i] = 0; mbuf[i] = 0; mvd[i] = 0; mrd[i] = 0;
            mtag[i] = 0; mvp[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R12: outputs quiet in reset
        compare("R12", {10'd0, busy, snp_shared, l1_flush_req, l1_inv, l1_grant, bus_req, bus_supply, mem_update}, 18'd0);
        rst_n = 1;
        @(negedge clk);
        compare("R12", {10'd0, busy, snp_shared, l1_flush_req, l1_inv, l1_grant, bus_req, bus_supply, mem_update}, 18'd0);

        // R12: every line empty after reset
        for (int ix = 0; ix < LINES; ix++) snoop(2'd0, {4'd5, 3'(ix)}, 0);

        // Sweep: setup x snoop kind per line
        for (int ix = 0; ix < LINES; ix++) begin
            for (int s = 0; s < 6; s++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [3:0] tg = 4'((ix + s + k) % 16);
                    logic [3:0] vp = 4'((ix * 3 + s + k) % 16);
                    logic [6:0] a  = {tg, 3'(ix)};
                    int dly = (s + k) % 3;
                    case (s)
                        1: cpu(3'd0, a, vp, 1, dly);
                        2: begin cpu(3'd0, a, vp, 0, dly); cpu(3'd2, a, vp, 0, dly); end
                        3: begin cpu(3'd1, a, vp, 0, dly); cpu(3'd4, a, vp, 0, dly); end
                        4: begin cpu(3'd1, a, vp, 0, dly); cpu(3'd4, a, vp, 0, dly); cpu(3'd5, a, vp, 0, dly); end
                        5: begin cpu(3'd0, a, vp, 1, dly); cpu(3'd3, a, vp, 0, dly); cpu(3'd2, a, vp, 0, dly); end
                        default: ;
                    endcase
                    snoop(2'd0, {tg ^ 4'h8, 3'(ix)}, dly);   // other tag: miss (R4)
                    snoop(2'(k), a, dly);
                    snoop(2'd0, a, dly);                      // observe leftover state
                    cpu(3'd2, a, vp, 0, dly);                  // sharing state via permission path
                    snoop(2'd1, a, dly);                      // cleanup, observes inclusion
                end
            end
        end

        // R2 priority: buffered data and fresh L1 dirty together
        cpu(3'd1, 7'h11, 4'h9, 0, 1);
        cpu(3'd4, 7'h11, 4'h9, 0, 0);
        cpu(3'd2, 7'h11, 4'h9, 0, 0);
        snoop(2'd0, 7'h11, 1);
        snoop(2'd1, 7'h11, 0);

        // R10: ops 6 and 7, and bookkeeping on a tag miss
        cpu(3'd1, 7'h22, 4'h3, 0, 0);
        cpu(3'd6, 7'h22, 4'h3, 0, 0);
        cpu(3'd7, 7'h22, 4'h3, 0, 0);
        cpu(3'd4, 7'h32, 4'h3, 0, 0);
        snoop(2'd0, 7'h22, 0);
        snoop(2'd1, 7'h22, 0);

        // R11: snoop and processor request together; only the snoop runs
        cpu(3'd0, 7'h43, 4'h7, 0, 0);
        run_txn(1, 2'd1, 1, 3'd3, 7'h43, 4'h7, 0, 0, 0);
        snoop(2'd0, 7'h43, 0);

        // R11: drop presented while busy is ignored; inclusion survives
        cpu(3'd1, 7'h54, 4'hA, 0, 0);
        run_txn(1, 2'd0, 0, 3'd0, 7'h54, 4'h0, 0, 2, 1);
        snoop(2'd1, 7'h54, 0);

        // R7: permission on a missing line does nothing
        cpu(3'd2, 7'h65, 4'h1, 0, 0);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule